// File: doc/BRIEF.md
# Multi-Port PCM Highway Interface

This block is the serial side of a line-card switch. It carries up to four duplex PCM ports, and all of them share one data clock and one frame sync. It keeps a bit counter and a time-slot counter that restart on each frame sync. Received serial bits are gathered into bytes, one byte per port per slot. Transmit bytes are serialised onto each port's data line.

The switching store sits outside the block. It follows `slot_o` and, in the same cycle, presents each port's transmit byte and a 2-bit slot-control code. For each port in each slot, that code chooses one of three things: the line floats, the line carries a programmable idle byte, or the line carries the supplied data. Every transmit line has a driver enable and an active-low tristate-control output, so that an external line driver can follow it.

The PCM mode sets how the 128-slot capacity is divided among the ports. A double-rate option lets the clock run at twice the bit rate. The frame sync can be sampled on either clock edge. A standby input silences every output while the counters and the receive path keep running.

Top module: `pcm_hwy`

## Requirements
- R1: While `rst_ni` is low, `slot_o` is 0 and `rx_valid_o` is 0.
- R2: `mode_i` sets the partitioning. 00 gives 4 ports of 32 slots, 01 gives 2 ports of 64 slots and 10 gives 1 port of 128 slots. A port whose index is not below the active port count never asserts its driver enable.
- R3: In mode 11, 4 ports run with `slot_num_i` slots per frame. Values below 4 are treated as 4, and values above 32 are treated as 32.
- R4: `fsync_i` is registered on the rising clock edge, or on the falling edge when `sync_fall_i` is 1. Bit 0 of slot 0 begins at the first rising edge where that registered value has newly become 1.
- R5: With no further sync, the slot counter wraps from the last slot of the frame to slot 0 and keeps counting.
- R6: Receive bits are taken MSB first and sampled on the falling clock edge. One rising edge after the end of each slot's bit 7, `rx_valid_o` pulses for exactly one cycle, together with that slot's index on `rx_slot_o` and the bytes on `rx_data_o` (port p in bits 8p+7..8p).
- R7: Transmit bits are sent MSB first and change on the rising edge. The control code for port p (bits 2p+1..2p of `tx_ctl_i`) works as follows: 00 floats the line, 01 sends `idle_i`, and 10 or 11 sends port p's byte of `tx_data_i` (bits 8p+7..8p).
- R8: With `dbl_rate_i` set, each bit lasts two clock cycles, and receive data is sampled in the second of them.
- R9: `tsc_no[p]` is low exactly when `txd_en_o[p]` is high. `txd_o[p]` is 0 whenever that port is not driving.
- R10: While `standby_i` is 1, no port drives. The slot counting and byte reception carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCM data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync |
| mode_i | input | 2 | Port/slot partitioning |
| slot_num_i | input | 6 | Slots per frame in mode 11 |
| dbl_rate_i | input | 1 | Clock runs at twice the bit rate |
| sync_fall_i | input | 1 | Sample the sync on the falling edge |
| standby_i | input | 1 | Float all transmit lines |
| idle_i | input | 8 | Idle byte |
| rxd_i | input | 4 | Receive data, one line per port |
| tx_data_i | input | 32 | Transmit bytes for the current slot |
| tx_ctl_i | input | 8 | Slot-control codes for the current slot |
| slot_o | output | 7 | Current slot index |
| txd_o | output | 4 | Transmit data |
| txd_en_o | output | 4 | Transmit driver enable |
| tsc_no | output | 4 | Tristate control, active low |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_slot_o | output | 7 | Slot of the received bytes |
| rx_data_o | output | 32 | Received bytes, all ports |

## Verification
Receiving and transmitting both happen on every bit cycle. A byte completes on one port in the same cycle that the next slot's first transmit bit goes out, and the same holds when standby is active. The bench provokes this overlap by driving independent byte patterns on all receive lines and per-slot patterns on the transmit inputs. It then judges both sides at once: it compares every transmit line in every cycle against a model kept from its own sync timing, and it checks each received byte through a queue against the item pushed when its last bit was driven. Frame restart against wrap-around is judged by letting a short programmed frame run past its end without a new sync.

// File: rtl/pcm_hwy_pkg.sv
package pcm_hwy_pkg;
  typedef enum logic [1:0] {
    MODE_4X32  = 2'b00,
    MODE_2X64  = 2'b01,
    MODE_1X128 = 2'b10,
    MODE_4XN   = 2'b11
  } pcm_mode_e;

  localparam logic [1:0] CTL_HIZ  = 2'b00;
  localparam logic [1:0] CTL_IDLE = 2'b01;

  function automatic logic [7:0] frame_slots(input logic [1:0] mode, input logic [5:0] prog);
    case (pcm_mode_e'(mode))
      MODE_4X32:  frame_slots = 8'd32;
      MODE_2X64:  frame_slots = 8'd64;
      MODE_1X128: frame_slots = 8'd128;
      default:    frame_slots = (prog < 6'd4) ? 8'd4 : (prog > 6'd32) ? 8'd32 : {2'b00, prog};
    endcase
  endfunction

  function automatic logic [2:0] active_ports(input logic [1:0] mode);
    case (pcm_mode_e'(mode))
      MODE_2X64:  active_ports = 3'd2;
      MODE_1X128: active_ports = 3'd1;
      default:    active_ports = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pcm_hwy_timing.sv
module pcm_hwy_timing #(
  parameter int SLOT_W = 7,
  parameter int BITS   = 8,
  localparam int BIT_W = $clog2(BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              sync_fall_i,
  input  logic              dbl_rate_i,
  input  logic [SLOT_W-1:0] last_slot_i,
  output logic              restart_o,
  output logic              bit_end_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic fs_pos, fs_neg, fs_sel, fs_d, phase;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fs_pos <= 1'b0;
    else         fs_pos <= fsync_i;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) fs_neg <= 1'b0;
    else         fs_neg <= fsync_i;

  assign fs_sel    = sync_fall_i ? fs_neg : fs_pos;
  assign restart_o = fs_sel & ~fs_d;
  assign bit_end_o = ~dbl_rate_i | phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_d   <= 1'b0;
      phase  <= 1'b0;
      bit_o  <= '0;
      slot_o <= '0;
    end else begin
      fs_d <= fs_sel;
      if (restart_o) begin
        phase  <= 1'b0;
        bit_o  <= '0;
        slot_o <= '0;
      end else begin
        phase <= dbl_rate_i & ~phase;
        if (bit_end_o) begin
          bit_o <= (bit_o == BIT_W'(BITS-1)) ? '0 : bit_o + 1'b1;
          if (bit_o == BIT_W'(BITS-1))
            slot_o <= (slot_o >= last_slot_i) ? '0 : slot_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_hwy_rx.sv
module pcm_hwy_rx #(
  parameter int NPORT  = 4,
  parameter int BITS   = 8,
  parameter int SLOT_W = 7,
  localparam int BIT_W = $clog2(BITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NPORT-1:0]      rxd_i,
  input  logic                  restart_i,
  input  logic                  bit_end_i,
  input  logic [BIT_W-1:0]      bit_i,
  input  logic [SLOT_W-1:0]     slot_i,
  output logic                  rx_valid_o,
  output logic [SLOT_W-1:0]     rx_slot_o,
  output logic [NPORT*BITS-1:0] rx_data_o
);
  logic [NPORT-1:0] rx_neg;
  logic             byte_done;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) rx_neg <= '0;
    else         rx_neg <= rxd_i;

  assign byte_done = ~restart_i & bit_end_i & (bit_i == BIT_W'(BITS-1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rx_valid_o <= 1'b0;
      rx_slot_o  <= '0;
    end else begin
      rx_valid_o <= byte_done;
      if (byte_done) rx_slot_o <= slot_i;
    end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [BITS-1:0] shreg;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        shreg                   <= '0;
        rx_data_o[p*BITS+:BITS] <= '0;
      end else begin
        if (bit_end_i && !restart_i) shreg <= {shreg[BITS-2:0], rx_neg[p]};
        if (byte_done) rx_data_o[p*BITS+:BITS] <= {shreg[BITS-2:0], rx_neg[p]};
      end
  end
endmodule

// File: rtl/pcm_hwy_tx.sv
module pcm_hwy_tx #(
  parameter int NPORT  = 4,
  parameter int BITS   = 8,
  localparam int BIT_W = $clog2(BITS)
) (
  input  logic [NPORT*BITS-1:0] tx_data_i,
  input  logic [2*NPORT-1:0]    tx_ctl_i,
  input  logic [BITS-1:0]       idle_i,
  input  logic [BIT_W-1:0]      bit_i,
  input  logic [2:0]            nports_i,
  input  logic                  standby_i,
  output logic [NPORT-1:0]      txd_o,
  output logic [NPORT-1:0]      txd_en_o,
  output logic [NPORT-1:0]      tsc_no
);
  import pcm_hwy_pkg::*;
  logic [BIT_W-1:0] msb_idx;
  assign msb_idx = BIT_W'(BITS-1) - bit_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [1:0]      code;
    logic [BITS-1:0] src;
    logic            en;
    assign code = tx_ctl_i[2*p+:2];
    assign src  = (code == CTL_IDLE) ? idle_i : tx_data_i[p*BITS+:BITS];
    assign en   = (32'(p) < 32'(nports_i)) && !standby_i && (code != CTL_HIZ);
    assign txd_en_o[p] = en;
    assign tsc_no[p]   = ~en;
    assign txd_o[p]    = en & src[msb_idx];
  end
endmodule

// File: rtl/pcm_hwy.sv
module pcm_hwy #(
  parameter int NPORT  = 4,
  parameter int BITS   = 8,
  parameter int SLOT_W = 7,
  localparam int BIT_W = $clog2(BITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fsync_i,
  input  logic [1:0]            mode_i,
  input  logic [5:0]            slot_num_i,
  input  logic                  dbl_rate_i,
  input  logic                  sync_fall_i,
  input  logic                  standby_i,
  input  logic [BITS-1:0]       idle_i,
  input  logic [NPORT-1:0]      rxd_i,
  input  logic [NPORT*BITS-1:0] tx_data_i,
  input  logic [2*NPORT-1:0]    tx_ctl_i,
  output logic [SLOT_W-1:0]     slot_o,
  output logic [NPORT-1:0]      txd_o,
  output logic [NPORT-1:0]      txd_en_o,
  output logic [NPORT-1:0]      tsc_no,
  output logic                  rx_valid_o,
  output logic [SLOT_W-1:0]     rx_slot_o,
  output logic [NPORT*BITS-1:0] rx_data_o
);
  import pcm_hwy_pkg::*;

  logic [7:0]        nslots;
  logic [SLOT_W-1:0] last_slot;
  logic              restart, bit_end;
  logic [BIT_W-1:0]  bit_cnt;

  assign nslots    = frame_slots(mode_i, slot_num_i);
  assign last_slot = SLOT_W'(nslots - 8'd1);

  pcm_hwy_timing #(.SLOT_W(SLOT_W), .BITS(BITS)) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni), .fsync_i(fsync_i), .sync_fall_i(sync_fall_i),
    .dbl_rate_i(dbl_rate_i), .last_slot_i(last_slot), .restart_o(restart),
    .bit_end_o(bit_end), .bit_o(bit_cnt), .slot_o(slot_o)
  );

  pcm_hwy_rx #(.NPORT(NPORT), .BITS(BITS), .SLOT_W(SLOT_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .restart_i(restart),
    .bit_end_i(bit_end), .bit_i(bit_cnt), .slot_i(slot_o),
    .rx_valid_o(rx_valid_o), .rx_slot_o(rx_slot_o), .rx_data_o(rx_data_o)
  );

  pcm_hwy_tx #(.NPORT(NPORT), .BITS(BITS)) u_tx (
    .tx_data_i(tx_data_i), .tx_ctl_i(tx_ctl_i), .idle_i(idle_i), .bit_i(bit_cnt),
    .nports_i(active_ports(mode_i)), .standby_i(standby_i),
    .txd_o(txd_o), .txd_en_o(txd_en_o), .tsc_no(tsc_no)
  );
endmodule

// File: rtl/pcm_hwy_chk.sv
module pcm_hwy_chk #(
  parameter int NPORT  = 4,
  parameter int SLOT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              standby_i,
  input logic [NPORT-1:0]  txd_o,
  input logic [NPORT-1:0]  txd_en_o,
  input logic [NPORT-1:0]  tsc_no,
  input logic              rx_valid_o,
  input logic [SLOT_W-1:0] slot_o
);
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |-> (txd_en_o == '0)); // R10

  AST_ONE_PORT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> ((txd_en_o >> 1) == '0)); // R2

  AST_TWO_PORTS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |-> ((txd_en_o >> 2) == '0)); // R2

  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R6

  AST_QUIET_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((txd_o & ~txd_en_o) == '0) && ((tsc_no & txd_en_o) == '0)); // R9

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o != $past(slot_o)) |-> (slot_o == '0 || slot_o == SLOT_W'($past(slot_o) + 1'b1))); // R5
endmodule

bind pcm_hwy pcm_hwy_chk #(.NPORT(NPORT), .SLOT_W(SLOT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .standby_i(standby_i),
  .txd_o(txd_o), .txd_en_o(txd_en_o), .tsc_no(tsc_no),
  .rx_valid_o(rx_valid_o), .slot_o(slot_o)
);

// File: tb/pcm_hwy_test.sv
`timescale 1ns/1ps
module pcm_hwy_test;
  localparam int NP = 4;
  localparam int BW = 8;
  localparam int SW = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, fsync, dbl, sfall, stby;
  logic [1:0] mode;
  logic [5:0] slot_num;
  logic [BW-1:0] idle;
  logic [NP-1:0] rxd;
  logic [NP*BW-1:0] tx_data;
  logic [2*NP-1:0] tx_ctl;
  logic [SW-1:0] slot_o, rx_slot_o;
  logic [NP-1:0] txd_o, txd_en_o, tsc_no;
  logic rx_valid_o;
  logic [NP*BW-1:0] rx_data_o;

  pcm_hwy uut (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .mode_i(mode), .slot_num_i(slot_num),
    .dbl_rate_i(dbl), .sync_fall_i(sfall), .standby_i(stby), .idle_i(idle), .rxd_i(rxd),
    .tx_data_i(tx_data), .tx_ctl_i(tx_ctl), .slot_o(slot_o), .txd_o(txd_o),
    .txd_en_o(txd_en_o), .tsc_no(tsc_no), .rx_valid_o(rx_valid_o),
    .rx_slot_o(rx_slot_o), .rx_data_o(rx_data_o)
  );

  typedef struct {
    int             slot;
    logic [NP*BW-1:0] data;
    int             np;
    string          tag;
  } rx_item_t;

  rx_item_t exp_q[$];
  int n_vec = 0, n_bad = 0;
  int seed = 0;
  logic mon_on = 1'b0;

  function automatic logic [7:0] rx_pat(int p, int s, int sd);
    return 8'((s * 37) + (p * 91) + (sd * 13) + 5);
  endfunction
  function automatic logic [7:0] tx_pat(int p, int s, int sd);
    return 8'((s * 29) ^ (p * 83) ^ (sd * 7) ^ 8'h3C);
  endfunction
  function automatic logic [1:0] ctl_pat(int p, int s, int sd);
    return 2'((s + p + sd) % 4);
  endfunction
  function automatic int model_slots(logic [1:0] m, int prog);
    case (m)
      2'b00: return 32;
      2'b01: return 64;
      2'b10: return 128;
      default: return (prog < 4) ? 4 : (prog > 32) ? 32 : prog;
    endcase
  endfunction
  function automatic int model_ports(logic [1:0] m);
    return (m == 2'b01) ? 2 : (m == 2'b10) ? 1 : 4;
  endfunction

  // switching-store stand-in: answers the current slot combinationally
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      tx_data[p*BW+:BW] = tx_pat(p, int'(slot_o), seed);
      tx_ctl[2*p+:2]    = ctl_pat(p, int'(slot_o), seed);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, expv, $time);
    end
  endtask

  // monitor: pops expected received bytes
  always @(negedge clk) begin
    if (mon_on && rst_n && rx_valid_o) begin
      if (exp_q.size() == 0) begin
        chk("R6 spurious rx_valid", 32'd1, 32'd0);
      end else begin
        rx_item_t it;
        it = exp_q.pop_front();
        chk(it.tag, 32'(rx_slot_o), 32'(it.slot));
        for (int p = 0; p < it.np; p++)
          chk(it.tag, 32'(rx_data_o[p*BW+:BW]), 32'(it.data[p*BW+:BW]));
      end
    end
  end

  task automatic run_frame(input logic [1:0] m, input int prog, input logic d, input logic f,
                           input logic sb, input int nsl, input int sd);
    int ns, np, cpb;
    mode = m; slot_num = 6'(prog); dbl = d; sfall = f; stby = sb; seed = sd;
    ns = model_slots(m, prog); np = model_ports(m); cpb = d ? 2 : 1;
    repeat (3) @(posedge clk);
    #1 fsync = 1'b1;
    @(posedge clk); #1 fsync = 1'b0;
    if (!f) begin @(posedge clk); #1; end   // R4: rising-edge sampling adds one cycle
    mon_on = 1'b1;
    for (int c = 0; c < nsl * 8 * cpb; c++) begin
      int bi, s, b;
      string stag;
      bi = c / cpb; s = (bi / 8) % ns; b = bi % 8;
      for (int p = 0; p < NP; p++) begin
        logic [7:0] rb;
        rb = rx_pat(p, s, sd);
        rxd[p] = rb[7-b];
      end
      #5;
      stag = (bi / 8 >= ns) ? "R5" : (m == 2'b11) ? "R3" : "R4";
      chk(stag, 32'(slot_o), 32'(s));
      for (int p = 0; p < NP; p++) begin
        logic [1:0] code;
        logic [7:0] tb, ib;
        logic en, bit_e;
        string etag;
        code = ctl_pat(p, s, sd);
        tb = tx_pat(p, s, sd); ib = idle;
        en = (p < np) && !sb && (code != 2'b00);
        bit_e = en ? (code[1] ? tb[7-b] : ib[7-b]) : 1'b0;
        etag = sb ? "R10" : (p >= np) ? "R2" : d ? "R8" : "R7";
        chk(etag, 32'(txd_en_o[p]), 32'(en));
        chk(d ? "R8" : "R7", 32'(txd_o[p]), 32'(bit_e));
        chk("R9", 32'(tsc_no[p]), 32'(!en));
      end
      if (b == 7 && (c % cpb) == cpb - 1) begin
        rx_item_t it;
        it.slot = s; it.np = np; it.data = '0;
        it.tag = sb ? "R10" : d ? "R8" : "R6";
        for (int p = 0; p < NP; p++) it.data[p*BW+:BW] = rx_pat(p, s, sd);
        exp_q.push_back(it);
      end
      @(posedge clk); #1;
    end
    @(negedge clk); @(negedge clk);
    mon_on = 1'b0;
    chk("R6 pending bytes", 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fsync = 1'b0; mode = 2'b00; slot_num = 6'd8; dbl = 1'b0;
    sfall = 1'b0; stby = 1'b0; idle = 8'hA5; rxd = '0;
    #25;
    chk("R1", 32'(slot_o), 32'd0);
    chk("R1", 32'(rx_valid_o), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    run_frame(2'b00, 0, 1'b0, 1'b0, 1'b0, 32, 1);   // R2 R4 R6 R7: 4x32, rising-edge sync
    run_frame(2'b01, 0, 1'b1, 1'b1, 1'b0, 64, 2);   // R2 R8: 2x64 double rate, falling-edge sync
    run_frame(2'b10, 0, 1'b0, 1'b1, 1'b0, 128, 3);  // R2: 1x128
    run_frame(2'b11, 5, 1'b1, 1'b0, 1'b0, 12, 4);   // R3 R5: 5 slots, runs past frame end
    run_frame(2'b11, 2, 1'b0, 1'b1, 1'b0, 6, 5);    // R3: clamp to 4 slots, wraps (R5)
    idle = 8'h3E;
    run_frame(2'b00, 0, 1'b0, 1'b0, 1'b1, 8, 6);    // R10: standby

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule